// File: doc/BRIEF.md
# DDR Write Burst Truncation Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It takes one write request at a time and turns it into a WRITE command, a fixed 8-beat data burst, and a PRECHARGE to the same bank. Each request carries a bank, a column, eight data beats and the number of beats that are really valid. When fewer than eight beats are valid, the PRECHARGE may land inside the unfinished burst. Every beat from the valid count onward is driven with its mask bit set and zero data.

Write recovery is counted in controller clocks only. It starts after the latest permitted strobe edge that captures the last valid beat. That edge is modelled as `DQSS_SKEW` clocks after the nominal data slot. Recovery runs for the programmed number of clocks, and the PRECHARGE goes out on the clock after that. The data path carries two beats per controller clock. The first pair follows the WRITE after `WR_LAT` clocks.

A ready/valid port refuses new work from the WRITE cycle through the PRECHARGE cycle. While idle, the block drives NOP with both mask bits set.

Top module: `ddrw_trunc_seq`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `cmd_code` is NOP (0), `dm_out` is 2'b11 and `dq_out` is zero.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle (tick 0), `cmd_code` is WRITE (1) with the latched bank and column. `req_ready` stays 0 from tick 0 through the PRECHARGE cycle and is 1 in the cycle after it.
- R3: Beat pair p (p = 0..3) appears in tick 1+p. Lane 0 (`dq_out[15:0]`, `dm_out[0]`) carries beat 2p and lane 1 (upper half, `dm_out[1]`) carries beat 2p+1. Beat i of the request is `req_data[16i+15:16i]`. A beat below the effective count N is driven with its mask bit at 0.
- R4: Every beat at index N or above is driven with its mask bit at 1 and zero data. This holds to the end of the burst, including pairs that fall in or after the PRECHARGE cycle.
- R5: The PRECHARGE (code 2) to the latched bank appears at tick 2 + floor((N-1)/2) + T, where T is the effective recovery setting. Every other busy cycle is NOP.
- R6: `cfg_twr` is sampled when the request is taken. A value of 0 acts as 1. A change during the burst has no effect on that request.
- R7: The effective beat count N is `req_beats` clamped to the range 1..8. A value of 0 acts as 1, and a value above 8 acts as 8.
- R8: `req_valid` during a busy interval is ignored. No extra WRITE is issued, and the bank, column and data of the request in progress are unchanged.
- R9: Each taken request produces exactly one WRITE and exactly one PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Start column |
| req_data | input | 128 | Eight 16-bit beats, beat 0 in the low bits |
| req_beats | input | 4 | Number of valid beats |
| cfg_twr | input | 3 | Write recovery in clocks |
| cmd_code | output | 2 | 0 NOP, 1 WRITE, 2 PRECHARGE |
| cmd_bank | output | 2 | Bank of the current command |
| cmd_col | output | 8 | Column of a WRITE, else zero |
| dq_out | output | 32 | Two beats of write data |
| dm_out | output | 2 | Mask bit for each beat, 1 = masked |

## Verification
The bench builds the block with its defaults: 16-bit beats, 2-bit bank, 8-bit column, write latency 1, one clock of strobe skew and a 3-bit recovery field. With these values the whole recovery range 1..7 and every beat count 1..8 can be driven. Short counts combined with a one-clock recovery place the PRECHARGE on the final data pair, so the bench sees masking of residual beats inside the truncated burst. The latest PRECHARGE slot is tick 12, which keeps every request within a few dozen clocks and allows back-to-back requests to follow one another directly.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  localparam int unsigned BURST_LEN = 8;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_PRE   = 2'd2
  } ddrw_cmd_e;

  // Effective valid-beat count: 1..BURST_LEN
  function automatic logic [3:0] clamp_beats(input logic [3:0] raw);
    if (raw == 4'd0) return 4'd1;
    if (raw > 4'(BURST_LEN)) return 4'(BURST_LEN);
    return raw;
  endfunction

  // Recovery setting: zero is lifted to one clock
  function automatic int unsigned clamp_twr(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Tick of the precharge, counted from the WRITE cycle (tick 0)
  function automatic int unsigned pre_slot(input int unsigned beats,
                                           input int unsigned twr,
                                           input int unsigned wl,
                                           input int unsigned skew);
    int unsigned last_pair;
    last_pair = (beats - 1) / 2;
    return wl + last_pair + skew + twr;
  endfunction

endpackage

// File: rtl/ddrw_req_stage.sv
module ddrw_req_stage
  import ddrw_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int TWR_W  = 3,
  parameter int TICK_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [BANK_W-1:0]             req_bank,
  input  logic [COL_W-1:0]              req_col,
  input  logic [BURST_LEN*DQ_W-1:0]     req_data,
  input  logic [3:0]                    req_beats,
  input  logic [TWR_W-1:0]              cfg_twr,
  input  logic                          pre_fire,
  output logic                          req_ready,
  output logic                          accept,
  output logic                          busy,
  output logic [TICK_W-1:0]             tick,
  output logic [BANK_W-1:0]             bank_q,
  output logic [COL_W-1:0]              col_q,
  output logic [BURST_LEN*DQ_W-1:0]     data_q,
  output logic [3:0]                    beats_q,
  output logic [TWR_W-1:0]              twr_q
);

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tick    <= '0;
      bank_q  <= '0;
      col_q   <= '0;
      data_q  <= '0;
      beats_q <= 4'd1;
      twr_q   <= TWR_W'(1);
    end else if (accept) begin
      busy    <= 1'b1;
      tick    <= '0;
      bank_q  <= req_bank;
      col_q   <= req_col;
      data_q  <= req_data;
      beats_q <= clamp_beats(req_beats);
      twr_q   <= TWR_W'(clamp_twr(32'(cfg_twr)));
    end else if (busy) begin
      tick <= tick + 1'b1;
      if (pre_fire) busy <= 1'b0;
    end
  end

  // R2
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |=> req_ready);

  // R8
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pre_fire) |=> ($stable(col_q) && $stable(bank_q) && $stable(data_q)));

endmodule

// File: rtl/ddrw_cmd_drive.sv
module ddrw_cmd_drive
  import ddrw_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int TWR_W     = 3,
  parameter int TICK_W    = 4,
  parameter int WR_LAT    = 1,
  parameter int DQSS_SKEW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [TICK_W-1:0] tick,
  input  logic [3:0]        beats_q,
  input  logic [TWR_W-1:0]  twr_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [COL_W-1:0]  col_q,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              write_fire,
  output logic              pre_fire
);

  logic [TICK_W-1:0] pre_tick;

  assign pre_tick   = TICK_W'(pre_slot(32'(beats_q), 32'(twr_q),
                                       32'(WR_LAT), 32'(DQSS_SKEW)));
  assign write_fire = busy && (tick == '0);
  assign pre_fire   = busy && (tick == pre_tick);

  always_comb begin
    cmd_code = CMD_NOP;
    cmd_bank = '0;
    cmd_col  = '0;
    if (write_fire) begin
      cmd_code = CMD_WRITE;
      cmd_bank = bank_q;
      cmd_col  = col_q;
    end else if (pre_fire) begin
      cmd_code = CMD_PRE;
      cmd_bank = bank_q;
    end
  end

  // R5
  pre_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |-> $past(cmd_code) == CMD_NOP);

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> !write_fire);

endmodule

// File: rtl/ddrw_beat_lane.sv
module ddrw_beat_lane
  import ddrw_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int DQ_W   = 16,
  parameter int TICK_W = 4,
  parameter int WR_LAT = 1
) (
  input  logic                      busy,
  input  logic [TICK_W-1:0]         tick,
  input  logic [3:0]                beats_q,
  input  logic [BURST_LEN*DQ_W-1:0] data_q,
  output logic [DQ_W-1:0]           dq,
  output logic                      dm
);

  localparam int PAIRS = BURST_LEN / 2;

  logic       in_burst;
  logic [3:0] beat_idx;
  logic       beat_live;

  assign in_burst  = busy && (32'(tick) >= WR_LAT) && (32'(tick) < WR_LAT + PAIRS);
  assign beat_idx  = 4'(2 * (32'(tick) - WR_LAT) + LANE);
  assign beat_live = in_burst && (beat_idx < beats_q);

  always_comb begin
    dm = 1'b1;
    dq = '0;
    if (beat_live) begin
      dm = 1'b0;
      dq = data_q[32'(beat_idx[2:0]) * DQ_W +: DQ_W];
    end
  end

endmodule

// File: rtl/ddrw_trunc_seq.sv
module ddrw_trunc_seq
  import ddrw_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int TWR_W     = 3,
  parameter int WR_LAT    = 1,
  parameter int DQSS_SKEW = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [COL_W-1:0]          req_col,
  input  logic [BURST_LEN*DQ_W-1:0] req_data,
  input  logic [3:0]                req_beats,
  input  logic [TWR_W-1:0]          cfg_twr,
  output logic [1:0]                cmd_code,
  output logic [BANK_W-1:0]         cmd_bank,
  output logic [COL_W-1:0]          cmd_col,
  output logic [2*DQ_W-1:0]         dq_out,
  output logic [1:0]                dm_out
);

  localparam int LANES    = 2;
  localparam int TICK_MAX = WR_LAT + BURST_LEN / 2 + DQSS_SKEW + (1 << TWR_W);
  localparam int TICK_W   = $clog2(TICK_MAX + 1);

  logic                      accept, busy, write_fire, pre_fire;
  logic [TICK_W-1:0]         tick;
  logic [BANK_W-1:0]         bank_q;
  logic [COL_W-1:0]          col_q;
  logic [BURST_LEN*DQ_W-1:0] data_q;
  logic [3:0]                beats_q;
  logic [TWR_W-1:0]          twr_q;

  ddrw_req_stage #(.DQ_W(DQ_W), .BANK_W(BANK_W), .COL_W(COL_W),
                   .TWR_W(TWR_W), .TICK_W(TICK_W)) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_data(req_data), .req_beats(req_beats),
    .cfg_twr(cfg_twr), .pre_fire(pre_fire), .req_ready(req_ready),
    .accept(accept), .busy(busy), .tick(tick), .bank_q(bank_q),
    .col_q(col_q), .data_q(data_q), .beats_q(beats_q), .twr_q(twr_q)
  );

  ddrw_cmd_drive #(.BANK_W(BANK_W), .COL_W(COL_W), .TWR_W(TWR_W),
                   .TICK_W(TICK_W), .WR_LAT(WR_LAT), .DQSS_SKEW(DQSS_SKEW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick), .beats_q(beats_q),
    .twr_q(twr_q), .bank_q(bank_q), .col_q(col_q), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .write_fire(write_fire),
    .pre_fire(pre_fire)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddrw_beat_lane #(.LANE(g), .DQ_W(DQ_W), .TICK_W(TICK_W), .WR_LAT(WR_LAT)) u_lane (
      .busy(busy), .tick(tick), .beats_q(beats_q), .data_q(data_q),
      .dq(dq_out[g*DQ_W +: DQ_W]), .dm(dm_out[g])
    );
  end

  // R2
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cmd_code == CMD_WRITE);

  // R4
  pre_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> (dm_out == 2'b11 && dq_out == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_code == CMD_NOP && dm_out == 2'b11));

  // R9
  one_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |=> (cmd_code != CMD_PRE));

endmodule

// File: tb/sim_ddrw_trunc_seq.sv
module sim_ddrw_trunc_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_bank = '0;
  logic [7:0]   req_col = '0;
  logic [127:0] req_data = '0;
  logic [3:0]   req_beats = 4'd8;
  logic [2:0]   cfg_twr = 3'd1;
  logic [1:0]   cmd_code, cmd_bank;
  logic [7:0]   cmd_col;
  logic [31:0]  dq_out;
  logic [1:0]   dm_out;

  int total = 0;
  int bad = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  ddrw_trunc_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_data(req_data),
    .req_beats(req_beats), .cfg_twr(cfg_twr), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .dq_out(dq_out), .dm_out(dm_out)
  );

  // {beats, twr, bank, col}
  localparam logic [16:0] VECS [8] = '{
    {4'd8, 3'd1, 2'd0, 8'h10}, {4'd2, 3'd1, 2'd1, 8'h20},
    {4'd4, 3'd3, 2'd2, 8'h33}, {4'd6, 3'd7, 2'd3, 8'h47},
    {4'd5, 3'd2, 2'd1, 8'h5A}, {4'd1, 3'd1, 2'd2, 8'h61},
    {4'd7, 3'd5, 2'd0, 8'h7E}, {4'd3, 3'd6, 2'd3, 8'h82}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  function automatic logic [15:0] beat_val(input int seed, input int i);
    return 16'((seed << 8) | (i << 4) | (15 - i));
  endfunction

  // Expected per the requirements: count clamp, twr clamp, precharge tick
  function automatic int exp_n(input int raw);
    if (raw == 0) return 1;
    if (raw > 8) return 8;
    return raw;
  endfunction

  task automatic run_req(input int beats, input int twr, input int bank,
                         input int col, input int seed,
                         input bit poke_twr, input bit flood);
    int n, t_eff, pre;
    logic [127:0] d;
    for (int i = 0; i < 8; i++) d[16*i +: 16] = beat_val(seed, i);
    n = exp_n(beats);
    t_eff = (twr == 0) ? 1 : twr;
    pre = 2 + (n - 1) / 2 + t_eff;
    req_valid = 1'b1;
    req_bank  = 2'(bank);
    req_col   = 8'(col);
    req_data  = d;
    req_beats = 4'(beats);
    cfg_twr   = 3'(twr);
    @(negedge clk);
    if (flood) begin
      req_col  = 8'hEE;
      req_bank = 2'(bank + 1);
      req_data = ~d;
    end else begin
      req_valid = 1'b0;
    end
    for (int t = 0; t <= pre + 1; t++) begin
      if (t == 0) begin
        chk(cmd_code == 2'd1, "R2", "write code", cmd_code, 1);
        chk(cmd_col == 8'(col) && cmd_bank == 2'(bank), "R2", "write addr",
            {cmd_bank, cmd_col}, {2'(bank), 8'(col)});
        chk(req_ready == 1'b0, "R2", "ready at write", req_ready, 0);
      end else if (t == pre) begin
        chk(cmd_code == 2'd2 && cmd_bank == 2'(bank), "R5", "precharge",
            {cmd_code, cmd_bank}, {2'd2, 2'(bank)});
        chk(req_ready == 1'b0, "R2", "ready at pre", req_ready, 0);
      end else if (t == pre + 1) begin
        chk(req_ready == 1'b1, "R2", "ready after pre", req_ready, 1);
        chk(cmd_code == 2'd0, "R9", "nop after pre", cmd_code, 0);
        req_valid = 1'b0;
      end else begin
        chk(cmd_code == 2'd0, flood ? "R8" : "R5", "nop slot", cmd_code, 0);
      end
      if (t >= 1 && t <= 4) begin
        for (int ln = 0; ln < 2; ln++) begin
          int b;
          b = 2 * (t - 1) + ln;
          if (b < n)
            chk(dm_out[ln] == 1'b0 && dq_out[16*ln +: 16] == d[16*b +: 16],
                flood ? "R8" : "R3", "live beat", {dm_out[ln], dq_out[16*ln +: 16]},
                {1'b0, d[16*b +: 16]});
          else
            chk(dm_out[ln] == 1'b1 && dq_out[16*ln +: 16] == 16'h0, "R4",
                "masked beat", {dm_out[ln], dq_out[16*ln +: 16]}, {1'b1, 16'h0});
        end
      end else if (t > 4 && t <= pre) begin
        chk(dm_out == 2'b11 && dq_out == 32'h0, "R4", "tail mask",
            {dm_out, dq_out}, {2'b11, 32'h0});
      end
      if (poke_twr && t == 1) cfg_twr = 3'd7;
      if (t < pre + 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    chk(cmd_code == 2'd0, "R1", "cmd", cmd_code, 0);
    chk(dm_out == 2'b11 && dq_out == 32'h0, "R1", "data idle",
        {dm_out, dq_out}, {2'b11, 32'h0});

    // Table walk: R3, R4, R5, R9, requests back to back
    for (int k = 0; k < 8; k++) begin
      logic [16:0] v;
      v = VECS[k];
      run_req(int'(v[16:13]), int'(v[12:10]), int'(v[9:8]), int'(v[7:0]), k + 1, 0, 0);
    end

    // R6 zero recovery acts as one
    run_req(2, 0, 1, 8'h91, 9, 0, 0);
    // R6 mid-burst change ignored
    run_req(4, 2, 2, 8'hA2, 10, 1, 0);
    // R7 count clamps
    run_req(0, 1, 0, 8'hB3, 11, 0, 0);
    run_req(12, 1, 3, 8'hC4, 12, 0, 0);
    // R8 requests offered while busy are refused
    run_req(6, 3, 1, 8'hD5, 13, 0, 1);
    // R1 idle after last request
    @(negedge clk);
    chk(cmd_code == 2'd0 && dm_out == 2'b11 && req_ready == 1'b1, "R1",
        "idle after", {req_ready, cmd_code, dm_out}, {1'b1, 2'd0, 2'b11});
    report();
    $finish;
  end

endmodule